// File: doc/BRIEF.md
# Indirect 64-bit Register Access Bridge

This block sits as a slave on a 32-bit host register bus. It gives the host access to a 64-bit register space behind it that the host cannot address directly. The host places a 64-bit value in two 32-bit staging windows, upper half and lower half. It then writes a command word that names the target register and the direction of the transfer. The block runs one access on a 64-bit request/acknowledge port and then goes idle.

For a read, the target's reply overwrites the two staging windows so that the host can collect it. Any failure leaves a sticky error flag in a status register: the target reporting an error, the target staying silent for too long, or the host issuing a command before the previous one has finished. The host checks the flag after each command. A write to a dedicated reset register clears the flag and abandons any access still in flight. An interrupt-enable register routes the error flag to an interrupt output.

Top module: `regbridge64`

## Requirements
- R1: After synchronous reset every host register reads 0, `tgt_req` is low and `irq` is low.
- R2: The host reads return data in the cycle after the read strobe, with `hst_rvalid` high for one cycle. The windows at 0x00 (upper) and 0x04 (lower) read back what the host wrote to them. An unmapped offset such as 0x0C reads 0.
- R3: A command write (offset 0x08) with bit 31 = 1 raises `tgt_req` at the same clock edge, with `tgt_we` = 1, `tgt_addr` = command bits 30:0 and `tgt_wdata` = {window 0x00, window 0x04}. These values stay stable while `tgt_req` is high.
- R4: A command write with bit 31 = 0 starts a read (`tgt_we` = 0). On the edge where `tgt_ack` is sampled high with `tgt_err` low, window 0x00 loads `tgt_rdata[63:32]`, window 0x04 loads `tgt_rdata[31:0]`, and `tgt_req` falls.
- R5: `tgt_err` sampled high while `tgt_req` is high ends the access and sets status bit 31. The windows keep their values.
- R6: If neither `tgt_ack` nor `tgt_err` arrives, `tgt_req` falls and status bit 31 is set at the 256th clock edge after the command edge. `tgt_req` is still high after the 255th edge.
- R7: A command written while an access is pending is ignored: `tgt_addr`, `tgt_we` and the command readback do not change. It also sets status bit 31.
- R8: Status bit 31 is sticky. A write of any value to offset 0x18 clears it and drops a pending `tgt_req` at that edge.
- R9: Status bit 0 (offset 0x1C) is high from the command edge until the access ends. All other status bits read 0.
- R10: Offset 0x20 bit 0 is an interrupt enable and reads back. `irq` equals this enable AND status bit 31.
- R11: Offset 0x08 reads back the last accepted command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr_en | input | 1 | Host write strobe |
| hst_rd_en | input | 1 | Host read strobe |
| hst_addr | input | HADDR_W | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, registered |
| hst_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| tgt_req | output | 1 | Target access request, held until the access ends |
| tgt_we | output | 1 | Target direction, 1 = write |
| tgt_addr | output | TADDR_W | Target register address |
| tgt_wdata | output | 64 | Target write data |
| tgt_ack | input | 1 | Target completion |
| tgt_err | input | 1 | Target error completion |
| tgt_rdata | input | 64 | Target read data, valid with tgt_ack |
| irq | output | 1 | Error interrupt |

## Verification
Host read data is due one edge after the read strobe. The bench queues the expected word when it issues the read and compares it when `hst_rvalid` shows. The request, address, direction and interrupt ports change at the very edge that samples a command, acknowledge, error or reset write, so the bench drives each stimulus at a falling edge and checks the ports at the next falling edge. The timeout check counts exactly 255 edges after the command edge to confirm that the request is still pending, then one edge more to see it drop with the error set.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int HOST_DW = 32;
  localparam int TGT_DW  = 64;

  localparam logic [7:0] OFS_DHI  = 8'h00;
  localparam logic [7:0] OFS_DLO  = 8'h04;
  localparam logic [7:0] OFS_CMD  = 8'h08;
  localparam logic [7:0] OFS_RST  = 8'h18;
  localparam logic [7:0] OFS_STAT = 8'h1C;
  localparam logic [7:0] OFS_IRQ  = 8'h20;

  localparam int CMD_DIR_BIT  = 31;
  localparam int STAT_ERR_BIT = 31;

  typedef enum logic {ENG_IDLE, ENG_WAIT} eng_state_t;
endpackage

// File: rtl/rb_err_sticky.sv
module rb_err_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clear_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)          flag_o <= 1'b0;
    else if (clear_i) flag_o <= 1'b0;
    else if (set_i)   flag_o <= 1'b1;
  end

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !flag_o);
  a_r5_event_sets: assert property (@(posedge clk) disable iff (rst)
    set_i && !clear_i |=> flag_o);
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    flag_o && !clear_i |=> flag_o);
endmodule

// File: rtl/rb_cmd_engine.sv
module rb_cmd_engine #(
  parameter int TADDR_W = 31,
  parameter int TIMEOUT = 256
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_go,
  input  logic [rb_pkg::HOST_DW-1:0] cmd_word,
  input  logic [rb_pkg::HOST_DW-1:0] stage_hi,
  input  logic [rb_pkg::HOST_DW-1:0] stage_lo,
  input  logic                       abort,
  input  logic                       tgt_ack,
  input  logic                       tgt_err,
  input  logic [rb_pkg::TGT_DW-1:0]  tgt_rdata,
  output logic                       tgt_req,
  output logic                       tgt_we,
  output logic [TADDR_W-1:0]         tgt_addr,
  output logic [rb_pkg::TGT_DW-1:0]  tgt_wdata,
  output logic                       busy,
  output logic                       cmd_accept,
  output logic                       rd_load,
  output logic [rb_pkg::TGT_DW-1:0]  rd_data,
  output logic                       err_evt
);
  import rb_pkg::*;

  localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT - 1);

  eng_state_t state_q;
  logic [CNT_W-1:0] cnt_q;
  logic done_ok, done_err, tmo, collide, finish;

  assign busy       = (state_q == ENG_WAIT);
  assign tgt_req    = busy;
  assign cmd_accept = cmd_go && !busy;
  assign collide    = cmd_go && busy;
  assign done_ok    = busy && !abort && tgt_ack && !tgt_err;
  assign done_err   = busy && !abort && tgt_err;
  assign tmo        = busy && !abort && !tgt_ack && !tgt_err && (cnt_q == TMO_LAST);
  assign finish     = abort || tgt_ack || tgt_err || (cnt_q == TMO_LAST);
  assign rd_load    = done_ok && !tgt_we;
  assign rd_data    = tgt_rdata;
  assign err_evt    = done_err || tmo || collide;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ENG_IDLE;
      cnt_q     <= '0;
      tgt_we    <= 1'b0;
      tgt_addr  <= '0;
      tgt_wdata <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (cmd_go) begin
            state_q   <= ENG_WAIT;
            cnt_q     <= '0;
            tgt_we    <= cmd_word[CMD_DIR_BIT];
            tgt_addr  <= cmd_word[TADDR_W-1:0];
            tgt_wdata <= {stage_hi, stage_lo};
          end
        end
        default: begin
          if (finish) state_q <= ENG_IDLE;
          else        cnt_q   <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  a_r3_req_from_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(tgt_req) |-> $past(cmd_go));
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
    tgt_req && $past(tgt_req) |-> $stable(tgt_addr) && $stable(tgt_wdata) && $stable(tgt_we));
  a_r4_ack_ends: assert property (@(posedge clk) disable iff (rst)
    tgt_req && tgt_ack |=> !tgt_req);
  a_r6_timeout_ends: assert property (@(posedge clk) disable iff (rst)
    tgt_req && cnt_q == TMO_LAST |=> !tgt_req);
  a_r7_collide_keeps: assert property (@(posedge clk) disable iff (rst)
    tgt_req && cmd_go |=> tgt_addr == $past(tgt_addr));
  a_r8_abort_drops: assert property (@(posedge clk) disable iff (rst)
    abort |=> !tgt_req);
endmodule

// File: rtl/rb_host_regs.sv
module rb_host_regs #(
  parameter int HADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hst_wr_en,
  input  logic                       hst_rd_en,
  input  logic [HADDR_W-1:0]         hst_addr,
  input  logic [rb_pkg::HOST_DW-1:0] hst_wdata,
  output logic [rb_pkg::HOST_DW-1:0] hst_rdata,
  output logic                       hst_rvalid,
  output logic                       wr_cmd,
  output logic                       wr_rst,
  input  logic                       cmd_accept,
  input  logic                       rd_load,
  input  logic [rb_pkg::TGT_DW-1:0]  rd_data,
  input  logic                       busy,
  input  logic                       err_flag,
  output logic [rb_pkg::HOST_DW-1:0] stage_hi,
  output logic [rb_pkg::HOST_DW-1:0] stage_lo,
  output logic                       irq_en
);
  import rb_pkg::*;

  localparam logic [HADDR_W-1:0] A_DHI  = HADDR_W'(OFS_DHI);
  localparam logic [HADDR_W-1:0] A_DLO  = HADDR_W'(OFS_DLO);
  localparam logic [HADDR_W-1:0] A_CMD  = HADDR_W'(OFS_CMD);
  localparam logic [HADDR_W-1:0] A_RST  = HADDR_W'(OFS_RST);
  localparam logic [HADDR_W-1:0] A_STAT = HADDR_W'(OFS_STAT);
  localparam logic [HADDR_W-1:0] A_IRQ  = HADDR_W'(OFS_IRQ);

  logic [HOST_DW-1:0] cmd_q;
  logic [HOST_DW-1:0] rd_mux;

  assign wr_cmd = hst_wr_en && (hst_addr == A_CMD);
  assign wr_rst = hst_wr_en && (hst_addr == A_RST);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_hi <= '0;
      stage_lo <= '0;
      cmd_q    <= '0;
      irq_en   <= 1'b0;
    end else begin
      if (rd_load) begin
        stage_hi <= rd_data[TGT_DW-1:HOST_DW];
        stage_lo <= rd_data[HOST_DW-1:0];
      end else if (hst_wr_en) begin
        if (hst_addr == A_DHI) stage_hi <= hst_wdata;
        if (hst_addr == A_DLO) stage_lo <= hst_wdata;
      end
      if (cmd_accept) cmd_q <= hst_wdata;
      if (hst_wr_en && hst_addr == A_IRQ) irq_en <= hst_wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (hst_addr)
      A_DHI:  rd_mux = stage_hi;
      A_DLO:  rd_mux = stage_lo;
      A_CMD:  rd_mux = cmd_q;
      A_STAT: begin
        rd_mux[STAT_ERR_BIT] = err_flag;
        rd_mux[0]            = busy;
      end
      A_IRQ:  rd_mux[0] = irq_en;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rdata  <= '0;
      hst_rvalid <= 1'b0;
    end else begin
      hst_rvalid <= hst_rd_en;
      if (hst_rd_en) hst_rdata <= rd_mux;
    end
  end

  a_r4_load_value: assert property (@(posedge clk) disable iff (rst)
    rd_load |=> {stage_hi, stage_lo} == $past(rd_data));
  a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    hst_rd_en |=> hst_rvalid);
endmodule

// File: rtl/regbridge64.sv
module regbridge64 #(
  parameter int HADDR_W = 8,
  parameter int TADDR_W = 31,
  parameter int TIMEOUT = 256
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hst_wr_en,
  input  logic                  hst_rd_en,
  input  logic [HADDR_W-1:0]    hst_addr,
  input  logic [31:0]           hst_wdata,
  output logic [31:0]           hst_rdata,
  output logic                  hst_rvalid,
  output logic                  tgt_req,
  output logic                  tgt_we,
  output logic [TADDR_W-1:0]    tgt_addr,
  output logic [63:0]           tgt_wdata,
  input  logic                  tgt_ack,
  input  logic                  tgt_err,
  input  logic [63:0]           tgt_rdata,
  output logic                  irq
);
  logic        wr_cmd, wr_rst, cmd_accept, rd_load, busy, err_evt, err_flag, irq_en;
  logic [31:0] stage_hi, stage_lo;
  logic [63:0] rd_data;

  rb_host_regs #(.HADDR_W(HADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .hst_wr_en(hst_wr_en), .hst_rd_en(hst_rd_en), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
    .wr_cmd(wr_cmd), .wr_rst(wr_rst), .cmd_accept(cmd_accept),
    .rd_load(rd_load), .rd_data(rd_data), .busy(busy), .err_flag(err_flag),
    .stage_hi(stage_hi), .stage_lo(stage_lo), .irq_en(irq_en)
  );

  rb_cmd_engine #(.TADDR_W(TADDR_W), .TIMEOUT(TIMEOUT)) u_eng (
    .clk(clk), .rst(rst),
    .cmd_go(wr_cmd), .cmd_word(hst_wdata), .stage_hi(stage_hi), .stage_lo(stage_lo),
    .abort(wr_rst), .tgt_ack(tgt_ack), .tgt_err(tgt_err), .tgt_rdata(tgt_rdata),
    .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .busy(busy), .cmd_accept(cmd_accept), .rd_load(rd_load), .rd_data(rd_data),
    .err_evt(err_evt)
  );

  rb_err_sticky u_err (
    .clk(clk), .rst(rst), .set_i(err_evt), .clear_i(wr_rst), .flag_o(err_flag)
  );

  assign irq = irq_en & err_flag;

  a_r10_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq |-> err_flag);
endmodule

// File: tb/tb_regbridge64.sv
`timescale 1ns/1ps
module tb_regbridge64;
  logic        clk = 0;
  logic        rst = 1;
  logic        hst_wr_en = 0, hst_rd_en = 0;
  logic [7:0]  hst_addr = 0;
  logic [31:0] hst_wdata = 0;
  logic [31:0] hst_rdata;
  logic        hst_rvalid;
  logic        tgt_req, tgt_we;
  logic [30:0] tgt_addr;
  logic [63:0] tgt_wdata;
  logic        tgt_ack = 0, tgt_err = 0;
  logic [63:0] tgt_rdata = 0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  regbridge64 dut (
    .clk(clk), .rst(rst), .hst_wr_en(hst_wr_en), .hst_rd_en(hst_rd_en),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .hst_rvalid(hst_rvalid), .tgt_req(tgt_req), .tgt_we(tgt_we),
    .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_ack(tgt_ack),
    .tgt_err(tgt_err), .tgt_rdata(tgt_rdata), .irq(irq)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_wr_en = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr_en = 0;
  endtask

  task automatic hread(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    hst_rd_en = 1; hst_addr = a;
    @(negedge clk);
    hst_rd_en = 0;
  endtask

  task automatic respond(input logic ack, input logic err, input logic [63:0] d);
    @(negedge clk);
    tgt_ack = ack; tgt_err = err; tgt_rdata = d;
    @(negedge clk);
    tgt_ack = 0; tgt_err = 0;
  endtask

  // monitor: compares host read data as it arrives
  always @(negedge clk) begin
    if (!rst && hst_rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2 unexpected read data actual=%h expected=none", hst_rdata);
      end else begin
        chk({32'h0, hst_rdata}, {32'h0, exp_q.pop_front()}, tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk({63'h0, tgt_req}, 64'h0, "R1 req after reset");
    chk({63'h0, irq}, 64'h0, "R1 irq after reset");
    hread(8'h00, 32'h0, "R1 data-high reset");
    hread(8'h1C, 32'h0, "R1 status reset");
    hread(8'h20, 32'h0, "R1 irq enable reset");

    // R2 staging and unmapped
    hwrite(8'h00, 32'hA5A5_0001);
    hwrite(8'h04, 32'h5A5A_0002);
    hread(8'h00, 32'hA5A5_0001, "R2 data-high readback");
    hread(8'h04, 32'h5A5A_0002, "R2 data-low readback");
    hread(8'h0C, 32'h0, "R2 unmapped reads zero");

    // R10 enable
    hwrite(8'h20, 32'h1);
    hread(8'h20, 32'h1, "R10 enable readback");
    chk({63'h0, irq}, 64'h0, "R10 irq low without error");

    // R3 write command
    hwrite(8'h08, 32'h8000_0123);
    chk({63'h0, tgt_req}, 64'h1, "R3 req raised");
    chk({63'h0, tgt_we}, 64'h1, "R3 direction write");
    chk({33'h0, tgt_addr}, 64'h123, "R3 target address");
    chk(tgt_wdata, 64'hA5A5_0001_5A5A_0002, "R3 write data order");
    hread(8'h1C, 32'h1, "R9 busy while pending");
    repeat (3) @(negedge clk);
    chk({33'h0, tgt_addr}, 64'h123, "R3 address held");
    respond(1, 0, 64'h0);
    chk({63'h0, tgt_req}, 64'h0, "R3 req drops after ack");
    chk({63'h0, irq}, 64'h0, "R3 no error on clean ack");
    hread(8'h08, 32'h8000_0123, "R11 command readback");
    hread(8'h1C, 32'h0, "R9 idle after ack");

    // R4 read command
    hwrite(8'h08, 32'h0000_0045);
    chk({63'h0, tgt_we}, 64'h0, "R4 direction read");
    chk({33'h0, tgt_addr}, 64'h45, "R4 read address");
    respond(1, 0, 64'h1122_3344_5566_7788);
    chk({63'h0, tgt_req}, 64'h0, "R4 req drops");
    hread(8'h00, 32'h1122_3344, "R4 upper half loaded");
    hread(8'h04, 32'h5566_7788, "R4 lower half loaded");

    // R5 target error
    hwrite(8'h08, 32'h0000_0046);
    respond(0, 1, 64'hDEAD_BEEF_DEAD_BEEF);
    chk({63'h0, tgt_req}, 64'h0, "R5 req drops on error");
    chk({63'h0, irq}, 64'h1, "R5 error flag set");
    hread(8'h00, 32'h1122_3344, "R5 data unchanged");
    hread(8'h1C, 32'h8000_0000, "R5 status error bit");

    // R8 sticky and clear
    repeat (5) @(negedge clk);
    chk({63'h0, irq}, 64'h1, "R8 error sticky");
    hwrite(8'h18, 32'h0);
    chk({63'h0, irq}, 64'h0, "R8 cleared by reset write");
    hread(8'h1C, 32'h0, "R8 status clear");

    // R7 collision
    hwrite(8'h08, 32'h0000_0010);
    hwrite(8'h08, 32'h8000_0020);
    chk({33'h0, tgt_addr}, 64'h10, "R7 address unchanged");
    chk({63'h0, tgt_we}, 64'h0, "R7 direction unchanged");
    chk({63'h0, irq}, 64'h1, "R7 collision sets error");
    hread(8'h08, 32'h0000_0010, "R7 command readback unchanged");
    hwrite(8'h18, 32'h5);
    chk({63'h0, tgt_req}, 64'h0, "R8 abort drops req");
    chk({63'h0, irq}, 64'h0, "R8 abort clears error");

    // R6 timeout
    hwrite(8'h08, 32'h0000_0077);
    repeat (255) @(negedge clk);
    chk({63'h0, tgt_req}, 64'h1, "R6 req still high at edge 255");
    chk({63'h0, irq}, 64'h0, "R6 no error before timeout");
    @(negedge clk);
    chk({63'h0, tgt_req}, 64'h0, "R6 req drops at edge 256");
    chk({63'h0, irq}, 64'h1, "R6 timeout sets error");
    hread(8'h04, 32'h5566_7788, "R6 data unchanged");

    // R10 disable masks irq
    hwrite(8'h20, 32'h0);
    chk({63'h0, irq}, 64'h0, "R10 irq masked");
    hread(8'h1C, 32'h8000_0000, "R10 error still set");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R2 missing read data actual=%0d expected=0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule